// File: doc/BRIEF.md
# Cluster Coincidence Track Lookup

This block finds the best muon track candidate in one cluster of eight detector sub-sectors. On every clock it takes one radial hit (a position and a deviation) and two azimuthal hits (each a position and a deviation). It packs all six fields into a single table address. A synchronous RAM table then returns a result word. The low bits of that word grade the track momentum and the top bit gives the charge sign.

Alongside the lookup, the block works out which sub-sector won. The radial position picks the row. Of the two azimuthal hits, the one with the smaller deviation is the straighter and so the higher-momentum candidate, and that hit picks the column. This index is registered in the same cycle as the RAM read, so it comes out aligned with the table result.

Before operation, software-independent test or configuration logic fills the table through a write port that is only open in load mode. After that the block accepts a new event on every cycle, with no dead time.

Top module: `track_lut_finder`

## Requirements
- R1: The lookup address is the concatenation, most significant first, of {r_pos, r_dev, pa_pos, pa_dev, pb_pos, pb_dev}. With the default widths (2, 3, 1, 2, 1, 2) this is an 11-bit address, and the reported result is the table word stored at that address.
- R2: A lookup presented at a clock edge appears on the outputs after exactly that one edge. The registered RAM read and the registered side-band data stay aligned.
- R3: A new lookup can be presented on every cycle. Back-to-back events each produce their own result in consecutive cycles.
- R4: A table write happens only when load_mode and wr_en are both high at a clock edge. A write request made with load_mode low leaves the table unchanged.
- R5: A lookup presented while load_mode is high produces out_valid=0, out_result=0 and out_sub=0 one cycle later.
- R6: out_valid is in_valid delayed by one cycle, gated by load_mode being low. Whenever out_valid is 0, out_result and out_sub are 0.
- R7: For a valid track, out_sub = {r_pos, sel}, where sel is 1 when pb_dev < pa_dev and 0 otherwise (a tie selects hit A).
- R8: Bits [2:0] of a table word are the momentum code: 0 means no track, 1 to 6 are the levels, and 7 is reserved. A word whose code is 0 or 7 is reported as out_result=0 and out_sub=0.
- R9: For codes 1 to 6 the whole table word is passed through unchanged, including the charge sign in bit [3].
- R10: While rst_n is low at a clock edge (synchronous, active low), the next outputs are out_valid=0, out_result=0 and out_sub=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_mode | input | 1 | Opens the table write port; lookups made in this mode are invalid |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W (11) | Table write address |
| wr_data | input | RES_W (4) | Table write word |
| in_valid | input | 1 | Event present this cycle |
| r_pos | input | R_POS_W (2) | Radial hit position |
| r_dev | input | R_DEV_W (3) | Radial deviation |
| pa_pos | input | P_POS_W (1) | Azimuthal hit A position |
| pa_dev | input | P_DEV_W (2) | Azimuthal hit A deviation magnitude |
| pb_pos | input | P_POS_W (1) | Azimuthal hit B position |
| pb_dev | input | P_DEV_W (2) | Azimuthal hit B deviation magnitude |
| out_valid | output | 1 | Result valid |
| out_result | output | RES_W (4) | {charge, momentum code} |
| out_sub | output | SUB_W (3) | Winning sub-sector index |

## Verification
The table is filled with a word computed from each address, so every address bit changes the result. A wrong field order or a dropped field in the packing therefore shows up as a wrong word.

A run of back-to-back vectors exercises several cases:
- vectors whose azimuthal deviations are ordered either way, to exercise the column choice;
- a vector with equal deviations, to expose the tie rule;
- entries overridden to code 0 with the charge bit set and to code 7, to separate the masking rules;
- an entry with the charge bit set on a real level, to show that pass-through is complete.

Directed steps cover three more cases: a write request made outside load mode, a lookup made inside load mode, and a reset applied with an event present.

// File: rtl/track_lut_pkg.sv
// Shared constants for the cluster track lookup.
// Assumes one cluster holds eight sub-sectors and momentum has six levels.
package track_lut_pkg;
    localparam int unsigned N_SUBSECTORS = 8;
    localparam int unsigned N_LEVELS     = 6;
endpackage

// File: rtl/track_addr_pack.sv
// Packs the radial and two azimuthal hit fields into one table address and
// chooses the azimuthal hit with the smaller deviation (ties go to hit A).
// Assumes deviations are unsigned magnitudes: smaller means higher momentum.
module track_addr_pack #(
    parameter int unsigned R_POS_W = 2,
    parameter int unsigned R_DEV_W = 3,
    parameter int unsigned P_POS_W = 1,
    parameter int unsigned P_DEV_W = 2,
    localparam int unsigned ADDR_W = R_POS_W + R_DEV_W + 2 * (P_POS_W + P_DEV_W),
    localparam int unsigned SUB_W  = R_POS_W + 1
) (
    input  logic [R_POS_W-1:0] r_pos,
    input  logic [R_DEV_W-1:0] r_dev,
    input  logic [P_POS_W-1:0] pa_pos,
    input  logic [P_DEV_W-1:0] pa_dev,
    input  logic [P_POS_W-1:0] pb_pos,
    input  logic [P_DEV_W-1:0] pb_dev,
    output logic [ADDR_W-1:0]  addr,
    output logic [SUB_W-1:0]   sub_idx
);
    logic pick_b;

    // Address packing: radial fields first, then hit A, then hit B.
    always_comb begin
        addr = {r_pos, r_dev, pa_pos, pa_dev, pb_pos, pb_dev};
    end

    // Candidate choice within one radial row: keep the straighter hit.
    always_comb begin
        pick_b  = (pb_dev < pa_dev);
        sub_idx = {r_pos, pick_b};
    end
endmodule

// File: rtl/track_sync_table.sv
// One-read, one-write synchronous RAM holding the coincidence table.
// The read data is registered, so a read costs one clock. Contents are not reset.
module track_sync_table #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 4,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Table update from the load port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered lookup read.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/track_lut_finder.sv
// Cluster track finder: packs the hit fields into a table address, reads a
// synchronous RAM table and delays the sub-sector index by one matching stage.
// Assumes the table is loaded (load_mode high) before lookups are trusted.
module track_lut_finder #(
    parameter int unsigned R_POS_W = 2,
    parameter int unsigned R_DEV_W = 3,
    parameter int unsigned P_POS_W = 1,
    parameter int unsigned P_DEV_W = 2,
    parameter int unsigned RES_W   = 4,
    localparam int unsigned ADDR_W = R_POS_W + R_DEV_W + 2 * (P_POS_W + P_DEV_W),
    localparam int unsigned SUB_W  = R_POS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [RES_W-1:0]   wr_data,
    input  logic               in_valid,
    input  logic [R_POS_W-1:0] r_pos,
    input  logic [R_DEV_W-1:0] r_dev,
    input  logic [P_POS_W-1:0] pa_pos,
    input  logic [P_DEV_W-1:0] pa_dev,
    input  logic [P_POS_W-1:0] pb_pos,
    input  logic [P_DEV_W-1:0] pb_dev,
    output logic               out_valid,
    output logic [RES_W-1:0]   out_result,
    output logic [SUB_W-1:0]   out_sub
);
    import track_lut_pkg::*;

    localparam int unsigned CODE_W = RES_W - 1;
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(N_LEVELS);

    logic [ADDR_W-1:0] look_addr;
    logic [SUB_W-1:0]  sub_comb;
    logic [RES_W-1:0]  tbl_q;
    logic [SUB_W-1:0]  sub_q;
    logic              valid_q;
    logic [CODE_W-1:0] code_q;
    logic              keep;

    track_addr_pack #(
        .R_POS_W(R_POS_W), .R_DEV_W(R_DEV_W),
        .P_POS_W(P_POS_W), .P_DEV_W(P_DEV_W)
    ) u_pack (
        .r_pos(r_pos), .r_dev(r_dev),
        .pa_pos(pa_pos), .pa_dev(pa_dev),
        .pb_pos(pb_pos), .pb_dev(pb_dev),
        .addr(look_addr), .sub_idx(sub_comb)
    );

    track_sync_table #(.AW(ADDR_W), .DW(RES_W)) u_table (
        .clk(clk),
        .we(load_mode && wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(look_addr),
        .rdata(tbl_q)
    );

    // Side-band stage matching the RAM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sub_q   <= '0;
        end else begin
            valid_q <= in_valid && !load_mode;
            sub_q   <= sub_comb;
        end
    end

    // Output gating: drop invalid lookups and out-of-range codes.
    always_comb begin
        code_q     = tbl_q[CODE_W-1:0];
        keep       = valid_q && (code_q != '0) && (code_q <= MAX_CODE);
        out_valid  = valid_q;
        out_result = keep ? tbl_q : '0;
        out_sub    = keep ? sub_q : '0;
    end
endmodule

// File: rtl/track_lut_finder_chk.sv
// Property checker for track_lut_finder, attached by bind below.
module track_lut_finder_chk #(
    parameter int unsigned R_POS_W = 2,
    parameter int unsigned RES_W   = 4,
    parameter int unsigned SUB_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_mode,
    input logic               in_valid,
    input logic [R_POS_W-1:0] r_pos,
    input logic               out_valid,
    input logic [RES_W-1:0]   out_result,
    input logic [SUB_W-1:0]   out_sub
);
    import track_lut_pkg::*;

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !load_mode) |=> out_valid);

    a_r6_no_event_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r5_load_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        load_mode |=> (!out_valid && out_result == '0 && out_sub == '0));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0 && out_sub == '0));

    a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[RES_W-2:0] <= (RES_W-1)'(N_LEVELS));

    a_r8_no_track_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (out_result[RES_W-2:0] == '0) |-> (out_sub == '0));

    a_r7_row_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[RES_W-2:0] != '0) |->
            (out_sub[SUB_W-1:1] == $past(r_pos)));
endmodule

bind track_lut_finder track_lut_finder_chk #(
    .R_POS_W(R_POS_W), .RES_W(RES_W), .SUB_W(SUB_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .in_valid(in_valid),
    .r_pos(r_pos), .out_valid(out_valid), .out_result(out_result),
    .out_sub(out_sub)
);

// File: tb/track_lut_finder_test.sv
module track_lut_finder_test;
    localparam int AW = 11;
    localparam int DEPTH = 1 << AW;
    localparam logic [10:0] ZERO_A = 11'h155;
    localparam logic [10:0] SEVEN_A = 11'h2AA;
    localparam logic [10:0] CHG_A  = 11'h0F3;
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        11'h000, 11'h7FF, ZERO_A, SEVEN_A, CHG_A, 11'h4C9,
        11'h61A, 11'h3B6, 11'h58D, 11'h0E4, 11'h28B, 11'h712
    };

    logic clk = 1'b0;
    logic rst_n, load_mode, wr_en, in_valid;
    logic [10:0] wr_addr, cur;
    logic [3:0] wr_data;
    logic out_valid;
    logic [3:0] out_result;
    logic [2:0] out_sub;
    logic [3:0] model [DEPTH];
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    track_lut_finder uut (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .in_valid(in_valid),
        .r_pos(cur[10:9]), .r_dev(cur[8:6]), .pa_pos(cur[5]), .pa_dev(cur[4:3]),
        .pb_pos(cur[2]), .pb_dev(cur[1:0]),
        .out_valid(out_valid), .out_result(out_result), .out_sub(out_sub)
    );

    function automatic logic [3:0] fill_word(input logic [10:0] a);
        return a[3:0] ^ a[7:4] ^ {1'b0, a[10:8]};
    endfunction

    function automatic logic [7:0] expect_of(input logic [10:0] v);
        logic [3:0] w;
        logic sel;
        w = model[v];
        sel = (v[1:0] < v[4:3]);
        if (w[2:0] == 3'd0 || w[2:0] == 3'd7) return {1'b1, 3'b000, 4'h0};
        return {1'b1, v[10:9], sel, w};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got valid/sub/result %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic write_word(input logic [10:0] a, input logic [3:0] d);
        @(negedge clk);
        load_mode = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        model[a] = d;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; load_mode = 1'b0; wr_en = 1'b0; in_valid = 1'b0;
        wr_addr = '0; wr_data = '0; cur = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {out_valid, out_sub, out_result}, 8'h00);
        rst_n = 1'b1;

        for (int a = 0; a < DEPTH; a++) write_word(11'(a), fill_word(11'(a)));
        write_word(ZERO_A, 4'b1000);
        write_word(SEVEN_A, 4'b0111);
        write_word(CHG_A, 4'b1101);
        @(negedge clk);
        load_mode = 1'b0; wr_en = 1'b0;

        // R1 R2 R3 R7 R8 R9: back-to-back vector walk
        for (int i = 0; i <= NV; i++) begin
            if (i < NV) begin
                cur = VEC[i]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            if (i < NV)
                check("R1/R2/R3/R7/R8/R9", {out_valid, out_sub, out_result}, expect_of(VEC[i]));
        end
        // R6: no event gives a quiet output
        check("R6", {out_valid, out_sub, out_result}, 8'h00);

        // R4: write request outside load mode is ignored
        wr_en = 1'b1; wr_addr = CHG_A; wr_data = 4'h0;
        @(negedge clk);
        wr_en = 1'b0; cur = CHG_A; in_valid = 1'b1;
        @(negedge clk);
        check("R4", {out_valid, out_sub, out_result}, {1'b1, CHG_A[10:9], 1'b0, 4'b1101});

        // R5: lookup during load mode is invalid
        load_mode = 1'b1; cur = CHG_A; in_valid = 1'b1;
        @(negedge clk);
        check("R5", {out_valid, out_sub, out_result}, 8'h00);
        load_mode = 1'b0;

        // R7: tie between deviations selects hit A
        cur = {2'd3, 3'd5, 1'b0, 2'd2, 1'b1, 2'd2}; in_valid = 1'b1;
        @(negedge clk);
        check("R7", {out_valid, out_sub, out_result}, expect_of({2'd3, 3'd5, 1'b0, 2'd2, 1'b1, 2'd2}));

        // R10: reset with an event present
        rst_n = 1'b0; cur = CHG_A; in_valid = 1'b1;
        @(negedge clk);
        check("R10", {out_valid, out_sub, out_result}, 8'h00);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule